// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of an out-of-order pipeline with five functional units: one integer/memory unit, two multipliers, one adder and one divider. Each cycle it takes one decoded instruction (an operation class, a destination register and two source registers). It decides whether that instruction may enter a unit. It also decides which units already holding an instruction may fetch their operands, and which finished units may retire their result to the register file. The datapaths, the register file and fetch sit outside. The block only gives the grants that steer them and reports where work is held back.

Hazards are resolved at three different points. Write-after-write is resolved when an instruction enters a unit, read-after-write when operands are fetched, and write-after-read when a result is retired. All three decisions come from two structures. The first is a per-unit entry holding the operation, the register names, the producer tags and the ready flags. The second is a per-register table that names the unit due to write each register. Instructions enter in program order, one per cycle. Once an instruction is in a unit it no longer holds back younger independent instructions, so those may finish first.

Each unit reports the end of its execution with a one-cycle pulse on `exec_done`. The upstream stage keeps `in_valid` and the instruction fields steady until a grant appears.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: Operation codes map to units as follows: 0 to unit 0 (integer/memory), 1 to unit 1 or unit 2 (multipliers), 2 and 3 to unit 3 (adder), 4 to unit 4 (divider). A valid instruction is granted to the lowest-numbered free unit of its class. `issue_grant` is one-hot or zero. Codes 5 to 7 are never granted. With no free unit of the class, `issue_stall` is high.
- R2: Issue is refused while the register table shows a pending writer for the destination register. This includes the cycle in which that writer retires. The grant comes in the following cycle.
- R3: A unit gets `read_grant` no earlier than the cycle after its issue, and only when neither source has a pending producer. While it waits it shows `read_stall`. When a producer retires in cycle c, a consumer waiting only on it gets `read_grant` in cycle c+1.
- R4: A finished unit is held with `write_stall` while another unit has a source naming its destination and that source is ready but not yet read. It retires in the cycle after that read.
- R5: An `exec_done` pulse is accepted only while the unit is executing, that is after its read grant. Pulses at other times have no effect.
- R6: A unit that accepted `exec_done` and faces no write-after-read conflict gets `write_grant` in the next cycle. Its `unit_busy` bit falls one cycle later.
- R7: When an instruction issues in the same cycle that the producer of one of its sources retires, that source counts as ready. With the other source free, the instruction reads in the next cycle.
- R8: A younger independent instruction may issue while an older one waits for operands, and may retire before it.
- R9: After reset all units are idle and no read, write or stall output is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Operation class code |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| exec_done | input | 5 | Per-unit end-of-execution pulse |
| issue_grant | output | 5 | Unit receiving the instruction this cycle |
| issue_stall | output | 1 | Instruction present but not accepted |
| read_grant | output | 5 | Unit may read its operands this cycle |
| read_stall | output | 5 | Unit waiting for a source to become ready |
| write_grant | output | 5 | Unit may write its result this cycle |
| write_stall | output | 5 | Unit finished but held by a pending reader |
| unit_busy | output | 5 | Unit holds an instruction |
| unit_op | output | 5x3 | Operation code held by each unit |

## Verification
The assertions check on every cycle the invariants that tie the grants to unit occupancy. Issue goes only to an idle unit and leaves it occupied. Read and write grants go only to occupied units, and never together. A write grant frees the unit on the next cycle. A retirement stall never coincides with a retirement. A completion pulse aimed at an idle unit never leads to a retirement. The hazard orderings can only be shown by the bench's scenarios. These are the divider waiting on the multiplier's result, the adder held back until the divider has read its old operand, the same-cycle forwarding into a newly issued instruction, and the refused issue onto a register that still has a pending writer. Each of these depends on a particular sequence of instructions and completions.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int NUM_FU = 5;
  localparam int UNIT_W = $clog2(NUM_FU);
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_INT = 3'd0;
  localparam logic [OP_W-1:0] OP_MUL = 3'd1;
  localparam logic [OP_W-1:0] OP_ADD = 3'd2;
  localparam logic [OP_W-1:0] OP_SUB = 3'd3;
  localparam logic [OP_W-1:0] OP_DIV = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_RD = 2'd1,
    ST_EXEC    = 2'd2,
    ST_DONE    = 2'd3
  } fu_stage_e;

  typedef struct packed {
    logic              vld;
    logic [UNIT_W-1:0] id;
  } unit_tag_t;

  // Units able to execute an operation class.
  function automatic logic [NUM_FU-1:0] units_for_op(logic [OP_W-1:0] op);
    case (op)
      OP_INT:         units_for_op = 5'b00001;
      OP_MUL:         units_for_op = 5'b00110;
      OP_ADD, OP_SUB: units_for_op = 5'b01000;
      OP_DIV:         units_for_op = 5'b10000;
      default:        units_for_op = 5'b00000;
    endcase
  endfunction

  // Isolate the lowest set bit.
  function automatic logic [NUM_FU-1:0] lowest_bit(logic [NUM_FU-1:0] v);
    lowest_bit = v & (~v + 1'b1);
  endfunction

  // Index of a one-hot vector (zero when empty).
  function automatic logic [UNIT_W-1:0] onehot_index(logic [NUM_FU-1:0] v);
    onehot_index = '0;
    for (int i = 0; i < NUM_FU; i++)
      if (v[i]) onehot_index = UNIT_W'(i);
  endfunction

  // A producer tag whose unit retires this cycle is already satisfied.
  function automatic unit_tag_t forward_tag(unit_tag_t t, logic [NUM_FU-1:0] wr);
    if (t.vld && wr[t.id]) forward_tag = '0;
    else                   forward_tag = t;
  endfunction

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_en,
  input  logic [REG_W-1:0]             set_reg,
  input  logic [UNIT_W-1:0]            set_unit,
  input  logic [NUM_FU-1:0]            clr_mask,
  input  logic [NUM_FU-1:0][REG_W-1:0] unit_dst,
  input  logic [REG_W-1:0]             look_dst,
  input  logic [REG_W-1:0]             look_src1,
  input  logic [REG_W-1:0]             look_src2,
  output unit_tag_t                    dst_tag,
  output unit_tag_t                    src1_tag,
  output unit_tag_t                    src2_tag
);

  logic [NUM_REGS-1:0] pending;
  logic [UNIT_W-1:0]   owner [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++)
        if (clr_mask[u]) pending[unit_dst[u]] <= 1'b0;
      if (set_en) begin
        pending[set_reg] <= 1'b1;
        owner[set_reg]   <= set_unit;
      end
    end
  end

  assign dst_tag  = '{vld: pending[look_dst],  id: owner[look_dst]};
  assign src1_tag = '{vld: pending[look_src1], id: owner[look_src1]};
  assign src2_tag = '{vld: pending[look_src2], id: owner[look_src2]};

endmodule

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
(
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  unit_tag_t         dst_tag,
  input  logic [NUM_FU-1:0] unit_busy,
  output logic [NUM_FU-1:0] issue_grant,
  output logic              issue_stall
);

  logic [NUM_FU-1:0] free_cand;
  logic              waw_hit;

  assign free_cand = units_for_op(in_op) & ~unit_busy;
  assign waw_hit   = dst_tag.vld;

  always_comb begin
    issue_grant = '0;
    if (in_valid && !waw_hit) issue_grant = lowest_bit(free_cand);
  end

  assign issue_stall = in_valid && (issue_grant == '0);

endmodule

// File: rtl/sb_fu_table.sv
module sb_fu_table
  import sb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_FU-1:0]            issue_grant,
  input  logic [OP_W-1:0]              in_op,
  input  logic [REG_W-1:0]             in_dst,
  input  logic [REG_W-1:0]             in_src1,
  input  logic [REG_W-1:0]             in_src2,
  input  unit_tag_t                    src1_tag,
  input  unit_tag_t                    src2_tag,
  input  logic [NUM_FU-1:0]            exec_done,
  output logic [NUM_FU-1:0]            unit_busy,
  output logic [NUM_FU-1:0][OP_W-1:0]  unit_op,
  output logic [NUM_FU-1:0][REG_W-1:0] unit_dst,
  output logic [NUM_FU-1:0]            read_grant,
  output logic [NUM_FU-1:0]            read_stall,
  output logic [NUM_FU-1:0]            write_grant,
  output logic [NUM_FU-1:0]            write_stall
);

  fu_stage_e                    stage [NUM_FU];
  logic [NUM_FU-1:0][REG_W-1:0] fj, fk;
  unit_tag_t                    qj [NUM_FU];
  unit_tag_t                    qk [NUM_FU];
  logic [NUM_FU-1:0]            rj, rk;
  logic [NUM_FU-1:0]            war_block;
  logic [NUM_FU-1:0]            wake_j, wake_k;
  unit_tag_t                    new_qj, new_qk;

  // Tags for a freshly issued entry, with same-cycle retirement folded in.
  assign new_qj = forward_tag(src1_tag, write_grant);
  assign new_qk = forward_tag(src2_tag, write_grant);

  // A finished unit must not overwrite a register another unit still has to read.
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_block[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++)
        if (f != u && ((rj[f] && fj[f] == unit_dst[u]) ||
                       (rk[f] && fk[f] == unit_dst[u])))
          war_block[u] = 1'b1;
    end
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    logic in_wait, in_done;
    assign in_wait        = (stage[u] == ST_WAIT_RD);
    assign in_done        = (stage[u] == ST_DONE);
    assign unit_busy[u]   = (stage[u] != ST_IDLE);
    assign read_grant[u]  = in_wait && rj[u] && rk[u];
    assign read_stall[u]  = in_wait && !(rj[u] && rk[u]);
    assign write_grant[u] = in_done && !war_block[u];
    assign write_stall[u] = in_done && war_block[u];
    assign wake_j[u]      = qj[u].vld && write_grant[qj[u].id];
    assign wake_k[u]      = qk[u].vld && write_grant[qk[u].id];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NUM_FU; u++) begin
        stage[u] <= ST_IDLE;
        qj[u]    <= '0;
        qk[u]    <= '0;
      end
      unit_op  <= '0;
      unit_dst <= '0;
      fj       <= '0;
      fk       <= '0;
      rj       <= '0;
      rk       <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        case (stage[u])
          ST_IDLE: if (issue_grant[u]) begin
            stage[u]    <= ST_WAIT_RD;
            unit_op[u]  <= in_op;
            unit_dst[u] <= in_dst;
            fj[u]       <= in_src1;
            fk[u]       <= in_src2;
            qj[u]       <= new_qj;
            qk[u]       <= new_qk;
            rj[u]       <= !new_qj.vld;
            rk[u]       <= !new_qk.vld;
          end
          ST_WAIT_RD: begin
            if (read_grant[u]) begin
              stage[u] <= ST_EXEC;
              rj[u]    <= 1'b0;
              rk[u]    <= 1'b0;
            end else begin
              if (wake_j[u]) begin
                rj[u] <= 1'b1;
                qj[u] <= '0;
              end
              if (wake_k[u]) begin
                rk[u] <= 1'b1;
                qk[u] <= '0;
              end
            end
          end
          ST_EXEC: if (exec_done[u]) stage[u] <= ST_DONE;
          ST_DONE: if (write_grant[u]) stage[u] <= ST_IDLE;
          default: stage[u] <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [OP_W-1:0]             in_op,
  input  logic [REG_W-1:0]            in_dst,
  input  logic [REG_W-1:0]            in_src1,
  input  logic [REG_W-1:0]            in_src2,
  input  logic [NUM_FU-1:0]           exec_done,
  output logic [NUM_FU-1:0]           issue_grant,
  output logic                        issue_stall,
  output logic [NUM_FU-1:0]           read_grant,
  output logic [NUM_FU-1:0]           read_stall,
  output logic [NUM_FU-1:0]           write_grant,
  output logic [NUM_FU-1:0]           write_stall,
  output logic [NUM_FU-1:0]           unit_busy,
  output logic [NUM_FU-1:0][OP_W-1:0] unit_op
);

  unit_tag_t                    dst_tag, src1_tag, src2_tag;
  logic [NUM_FU-1:0][REG_W-1:0] unit_dst;
  logic                         issue_fire;
  logic [UNIT_W-1:0]            issue_unit;

  assign issue_fire = |issue_grant;
  assign issue_unit = onehot_index(issue_grant);

  sb_reg_status #(.NUM_REGS(NUM_REGS)) u_regstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (issue_fire),
    .set_reg   (in_dst),
    .set_unit  (issue_unit),
    .clr_mask  (write_grant),
    .unit_dst  (unit_dst),
    .look_dst  (in_dst),
    .look_src1 (in_src1),
    .look_src2 (in_src2),
    .dst_tag   (dst_tag),
    .src1_tag  (src1_tag),
    .src2_tag  (src2_tag)
  );

  sb_issue_sel u_issue (
    .in_valid    (in_valid),
    .in_op       (in_op),
    .dst_tag     (dst_tag),
    .unit_busy   (unit_busy),
    .issue_grant (issue_grant),
    .issue_stall (issue_stall)
  );

  sb_fu_table #(.REG_W(REG_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_grant (issue_grant),
    .in_op       (in_op),
    .in_dst      (in_dst),
    .in_src1     (in_src1),
    .in_src2     (in_src2),
    .src1_tag    (src1_tag),
    .src2_tag    (src2_tag),
    .exec_done   (exec_done),
    .unit_busy   (unit_busy),
    .unit_op     (unit_op),
    .unit_dst    (unit_dst),
    .read_grant  (read_grant),
    .read_stall  (read_stall),
    .write_grant (write_grant),
    .write_stall (write_stall)
  );

endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
module sb_hazard_ctrl_chk
  import sb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_FU-1:0] issue_grant,
  input logic [NUM_FU-1:0] read_grant,
  input logic [NUM_FU-1:0] read_stall,
  input logic [NUM_FU-1:0] write_grant,
  input logic [NUM_FU-1:0] write_stall,
  input logic [NUM_FU-1:0] unit_busy,
  input logic [NUM_FU-1:0] exec_done
);

  p_issue_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_grant));

  p_issue_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant & unit_busy) == '0);

  p_issue_occupies_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|issue_grant) |=> ((unit_busy & $past(issue_grant)) == $past(issue_grant)));

  p_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (read_grant & ~unit_busy) == '0);

  p_read_write_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (read_grant & write_grant) == '0);

  p_write_stall_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (write_grant & write_stall) == '0);

  p_idle_done_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((exec_done & ~unit_busy) != '0) |=>
      ((write_grant & $past(exec_done & ~unit_busy)) == '0));

  p_free_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|write_grant) |=> ((unit_busy & $past(write_grant)) == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((read_stall | write_stall | write_grant) & ~unit_busy) == '0);

endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk u_chk (.*);

// File: tb/sb_hazard_ctrl_bench.sv
module sb_hazard_ctrl_bench;

  localparam int NREG = 32;
  localparam int RW   = 5;
  localparam int NU   = 5;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic [2:0]          in_op = '0;
  logic [RW-1:0]       in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NU-1:0]       exec_done = '0;
  logic [NU-1:0]       issue_grant, read_grant, read_stall;
  logic [NU-1:0]       write_grant, write_stall, unit_busy;
  logic                issue_stall;
  logic [NU-1:0][2:0]  unit_op;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sb_hazard_ctrl #(.NUM_REGS(NREG)) u_sb_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .exec_done(exec_done), .issue_grant(issue_grant),
    .issue_stall(issue_stall), .read_grant(read_grant),
    .read_stall(read_stall), .write_grant(write_grant),
    .write_stall(write_stall), .unit_busy(unit_busy), .unit_op(unit_op)
  );

  // Vector: {op, dst, src1, src2, expected issue_grant}; one per cycle, no completions.
  localparam int NVEC = 10;
  localparam logic [22:0] VEC [NVEC] = '{
    {3'd0, 5'd1, 5'd0, 5'd0, 5'b00001},
    {3'd1, 5'd2, 5'd1, 5'd3, 5'b00010},
    {3'd1, 5'd4, 5'd2, 5'd3, 5'b00100},
    {3'd1, 5'd5, 5'd0, 5'd0, 5'b00000},
    {3'd2, 5'd2, 5'd0, 5'd0, 5'b00000},
    {3'd3, 5'd6, 5'd0, 5'd0, 5'b01000},
    {3'd4, 5'd7, 5'd6, 5'd6, 5'b10000},
    {3'd0, 5'd8, 5'd0, 5'd0, 5'b00000},
    {3'd5, 5'd9, 5'd0, 5'd0, 5'b00000},
    {3'd2, 5'd9, 5'd0, 5'd0, 5'b00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance to the next falling edge, then let combinational outputs settle.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [RW-1:0] d,
                       input logic [RW-1:0] s1, input logic [RW-1:0] s2);
    in_valid = v; in_op = op; in_dst = d; in_src1 = s1; in_src2 = s2;
  endtask

  task automatic do_reset();
    drive(1'b0, 3'd0, '0, '0, '0);
    exec_done = '0;
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R9: reset state
    rst_n = 1'b0;
    tick(); #2;
    chk("R9 busy in reset", 32'(unit_busy), 32'd0);
    chk("R9 grants in reset", 32'({issue_grant, read_grant, write_grant}), 32'd0);
    rst_n = 1'b1;
    tick(); #2;
    chk("R9 stalls after reset", 32'({read_stall, write_stall, issue_stall}), 32'd0);

    // R1/R2: vector walk
    for (int i = 0; i < NVEC; i++) begin
      tick();
      drive(1'b1, VEC[i][22:20], VEC[i][19:15], VEC[i][14:10], VEC[i][9:5]);
      #2;
      chk($sformatf("R1/R2 vec %0d issue_grant", i), 32'(issue_grant), 32'(VEC[i][4:0]));
      chk($sformatf("R1/R2 vec %0d issue_stall", i), 32'(issue_stall),
          32'(VEC[i][4:0] == 5'd0));
    end
    tick(); #2;
    chk("R1 unit_op of adder holds sub", 32'(unit_op[3]), 32'd3);

    // Hazard scenario
    do_reset();
    tick(); drive(1'b1, 3'd1, 5'd2, 5'd4, 5'd5); #2;                 // t0 MUL r2
    chk("R1 mul to unit1", 32'(issue_grant), 32'b00010);
    tick(); drive(1'b1, 3'd4, 5'd10, 5'd2, 5'd6); #2;                // t1 DIV r10 <- r2,r6
    chk("R1 div to unit4", 32'(issue_grant), 32'b10000);
    chk("R3 mul reads next cycle", 32'(read_grant), 32'b00010);
    tick(); drive(1'b1, 3'd2, 5'd6, 5'd8, 5'd9); #2;                 // t2 ADD r6
    chk("R8 add issues past waiting div", 32'(issue_grant), 32'b01000);
    chk("R3 div waits on r2", 32'(read_grant[4]), 32'd0);
    chk("R3 div read_stall", 32'(read_stall[4]), 32'd1);
    tick(); drive(1'b0, 3'd0, '0, '0, '0); exec_done = 5'b10000; #2; // t3 stray div pulse
    chk("R3 add reads", 32'(read_grant), 32'b01000);
    tick(); exec_done = 5'b01000; #2;                                 // t4
    chk("R5 no write yet", 32'(write_grant), 32'd0);
    tick(); exec_done = '0; #2;                                       // t5
    chk("R4 add held by div reader", 32'(write_stall), 32'b01000);
    chk("R4 add not granted", 32'(write_grant), 32'd0);
    tick(); exec_done = 5'b00010; #2;                                 // t6
    chk("R4 add still held", 32'(write_stall[3]), 32'd1);
    tick(); exec_done = '0; #2;                                       // t7
    chk("R6 mul writes", 32'(write_grant), 32'b00010);
    tick(); #2;                                                       // t8
    chk("R3 div reads after producer", 32'(read_grant), 32'b10000);
    chk("R6 mul freed", 32'(unit_busy[1]), 32'd0);
    chk("R4 add held until read done", 32'(write_stall[3]), 32'd1);
    tick(); drive(1'b1, 3'd0, 5'd11, 5'd6, 5'd1); #2;                // t9 INT r11 <- r6
    chk("R4 add writes after div read", 32'(write_grant), 32'b01000);
    chk("R8 add retires before div", 32'(unit_busy[4]), 32'd1);
    chk("R7 int issued during write", 32'(issue_grant), 32'b00001);
    tick(); drive(1'b0, 3'd0, '0, '0, '0); #2;                       // t10
    chk("R7 int reads forwarded source", 32'(read_grant), 32'b00001);
    chk("R5 stray pulse ignored", 32'(write_grant[4]), 32'd0);
    chk("R6 adder freed", 32'(unit_busy[3]), 32'd0);
    tick(); exec_done = 5'b10000; drive(1'b1, 3'd1, 5'd10, 5'd1, 5'd1); #2; // t11
    chk("R2 waw stall on r10", 32'(issue_stall), 32'd1);
    tick(); exec_done = '0; #2;                                       // t12
    chk("R6 div writes", 32'(write_grant), 32'b10000);
    chk("R2 stall during writer retire", 32'(issue_stall), 32'd1);
    tick(); #2;                                                       // t13
    chk("R2 issue after writer gone", 32'(issue_grant), 32'b00010);
    tick(); drive(1'b0, 3'd0, '0, '0, '0);

    summary();
  end

endmodule